// File: doc/BRIEF.md
# Flash Program/Erase Status Poller

This block sits on the host side of a parallel NOR-style flash device. After software or another controller has issued a program or erase command, it uses this block to learn what the device is doing. One request makes a poll, which is two back-to-back reads of the device's 8-bit data bus. The bitwise difference of the two samples (the toggle mask) and the first sample together decide the outcome. The block returns one of five codes with a single-cycle done pulse.

Some patterns are ambiguous because the device may complete its operation between the two reads. A lone erase-suspend toggle and any pattern the rules do not cover are two such cases. For these the block runs one more full poll before it commits to a verdict. A set failure flag in the first sample (bit 5) does not count as a fault unless bit 6 toggled too, because finished array data such as 0xFF also has that bit set.

The read interface is a single strobe held for a configurable number of wait cycles. The data bus is sampled on the strobe's last cycle. The result code is registered and holds its value until the next done pulse.

Top module: `flash_toggle_poller`

## Requirements
- R1: While reset is high and in the cycle after it, done_o is 0, status_o is 0 (READY) and rd_strobe_o is 0.
- R2: Each read keeps rd_strobe_o high for exactly WAIT_CYCLES+1 cycles, and rd_data_i is sampled only in the last of them. A poll is two reads, with one low strobe cycle between them.
- R3: A toggle mask (first sample XOR second sample) of zero gives code 0 (READY).
- R4: A mask with bit 6 set and bit 5 of the first sample clear gives code 1 (BUSY).
- R5: A mask with bit 6 set and bit 5 of the first sample set gives code 3 (TIMEOUT). Bit 5 set with no toggling (for example 0xFF twice) gives READY.
- R6: A mask equal to exactly 0x04 starts a second poll. If that poll also gives 0x04, the code is 2 (ERASE_SUSPENDED).
- R7: A nonzero mask that is neither 0x04 nor has bit 6 set starts a second poll. If the second poll is again of that kind, the code is 4 (ERROR).
- R8: A request makes at most two polls. The second poll is classified by R3 to R5 as usual. Where it would need a further retry, it ends instead in code 2 for mask 0x04 and code 4 otherwise.
- R9: done_o is a one-cycle pulse. It rises N*(2*WAIT_CYCLES+5) cycles after the clock edge that accepted start_i, where N is the number of polls. status_o changes only together with done_o and holds its value between pulses.
- R10: start_i is ignored while a request is in progress. It causes no extra read and no extra done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a status poll; taken only when idle |
| rd_strobe_o | output | 1 | Read strobe to the flash data bus |
| rd_data_i | input | DATA_W | Flash data bus |
| done_o | output | 1 | One-cycle pulse: status_o carries a new result |
| status_o | output | 3 | Result: 0 READY, 1 BUSY, 2 ERASE_SUSPENDED, 3 TIMEOUT, 4 ERROR |

## Verification
The assertions check the following on every cycle: the strobe width, that each request performs either two or four reads, that done is a single pulse, that the code changes only with done and stays in the legal range, and the reset state. Which code each data pattern yields cannot be seen by a property. The bench scenarios show that decision, including the retry paths where the second poll resolves, persists or turns into something else, the sampling point inside the strobe, and that a start during a busy request is ignored.

// File: rtl/ftp_pkg.sv
package ftp_pkg;

  typedef enum logic [2:0] {
    CODE_READY   = 3'd0,
    CODE_BUSY    = 3'd1,
    CODE_ESUSP   = 3'd2,
    CODE_TIMEOUT = 3'd3,
    CODE_ERROR   = 3'd4
  } poll_code_t;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_FIRST,
    SQ_SECOND,
    SQ_JUDGE
  } seq_state_t;

  // Extra polls allowed per request
  localparam int unsigned RETRY_MAX = 1;

  // Bit roles on the data bus; the classifier decodes these positions
  localparam int unsigned SUSP_BIT = 2;
  localparam int unsigned FAIL_BIT = 5;
  localparam int unsigned TOG_BIT  = 6;

endpackage

// File: rtl/ftp_bus_reader.sv
module ftp_bus_reader #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned WAIT_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              strobe_o,
  output logic [DATA_W-1:0] data_o,
  output logic              vld_o
);
  localparam int unsigned CNT_W = (WAIT_CYCLES < 1) ? 1 : $clog2(WAIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYCLES);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_o <= 1'b0;
      cnt      <= '0;
      data_o   <= '0;
      vld_o    <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (!strobe_o) begin
        if (req_i) begin
          strobe_o <= 1'b1;
          cnt      <= '0;
        end
      end else if (cnt == LAST) begin
        strobe_o <= 1'b0;
        data_o   <= rd_data_i;
        vld_o    <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ftp_classifier.sv
module ftp_classifier
  import ftp_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] first_i,
  input  logic [DATA_W-1:0] second_i,
  input  logic              retry_avail_i,
  output poll_code_t        code_o,
  output logic              retry_o
);
  localparam logic [DATA_W-1:0] SUSP_MASK = DATA_W'(1) << SUSP_BIT;

  logic [DATA_W-1:0] tmask;

  always_comb begin
    tmask   = first_i ^ second_i;
    retry_o = 1'b0;
    code_o  = CODE_READY;
    if (tmask == '0) begin
      code_o = CODE_READY;
    end else if (tmask == SUSP_MASK) begin
      code_o  = CODE_ESUSP;
      retry_o = retry_avail_i;
    end else if (tmask[TOG_BIT]) begin
      code_o = first_i[FAIL_BIT] ? CODE_TIMEOUT : CODE_BUSY;
    end else begin
      code_o  = CODE_ERROR;
      retry_o = retry_avail_i;
    end
  end

endmodule

// File: rtl/ftp_sequencer.sv
module ftp_sequencer
  import ftp_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] data_i,
  input  poll_code_t        code_i,
  input  logic              retry_i,
  output logic              req_o,
  output logic [DATA_W-1:0] first_o,
  output logic [DATA_W-1:0] second_o,
  output logic              retry_avail_o,
  output logic              done_o,
  output logic [2:0]        status_o
);
  localparam int unsigned BUD_W = $clog2(RETRY_MAX + 1);

  seq_state_t       state;
  logic [BUD_W-1:0] budget;

  assign retry_avail_o = (budget != '0);

  always_comb begin
    unique case (state)
      SQ_IDLE:  req_o = start_i;
      SQ_FIRST: req_o = vld_i;
      SQ_JUDGE: req_o = retry_i;
      default:  req_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_IDLE;
      budget   <= '0;
      first_o  <= '0;
      second_o <= '0;
      done_o   <= 1'b0;
      status_o <= CODE_READY;
    end else begin
      done_o <= 1'b0;
      unique case (state)
        SQ_IDLE: begin
          if (start_i) begin
            budget <= BUD_W'(RETRY_MAX);
            state  <= SQ_FIRST;
          end
        end
        SQ_FIRST: begin
          if (vld_i) begin
            first_o <= data_i;
            state   <= SQ_SECOND;
          end
        end
        SQ_SECOND: begin
          if (vld_i) begin
            second_o <= data_i;
            state    <= SQ_JUDGE;
          end
        end
        SQ_JUDGE: begin
          if (retry_i) begin
            budget <= budget - 1'b1;
            state  <= SQ_FIRST;
          end else begin
            status_o <= code_i;
            done_o   <= 1'b1;
            state    <= SQ_IDLE;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flash_toggle_poller.sv
module flash_toggle_poller
  import ftp_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned WAIT_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  output logic              rd_strobe_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              done_o,
  output logic [2:0]        status_o
);
  logic              req;
  logic              vld;
  logic [DATA_W-1:0] sample;
  logic [DATA_W-1:0] first_s;
  logic [DATA_W-1:0] second_s;
  logic              retry_avail;
  logic              retry;
  poll_code_t        code;

  ftp_bus_reader #(.DATA_W(DATA_W), .WAIT_CYCLES(WAIT_CYCLES)) u_reader (
    .clk       (clk),
    .rst       (rst),
    .req_i     (req),
    .rd_data_i (rd_data_i),
    .strobe_o  (rd_strobe_o),
    .data_o    (sample),
    .vld_o     (vld)
  );

  ftp_classifier #(.DATA_W(DATA_W)) u_class (
    .first_i       (first_s),
    .second_i      (second_s),
    .retry_avail_i (retry_avail),
    .code_o        (code),
    .retry_o       (retry)
  );

  ftp_sequencer #(.DATA_W(DATA_W)) u_seq (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start_i),
    .vld_i         (vld),
    .data_i        (sample),
    .code_i        (code),
    .retry_i       (retry),
    .req_o         (req),
    .first_o       (first_s),
    .second_o      (second_s),
    .retry_avail_o (retry_avail),
    .done_o        (done_o),
    .status_o      (status_o)
  );

endmodule

// File: rtl/ftp_checker.sv
module ftp_checker #(
  parameter int unsigned WAIT_CYCLES = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       rd_strobe_o,
  input logic       done_o,
  input logic [2:0] status_o
);
  logic [15:0] hi_cnt;
  logic [3:0]  rises;
  logic        strobe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt   <= '0;
      rises    <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= rd_strobe_o;
      hi_cnt   <= rd_strobe_o ? hi_cnt + 16'd1 : 16'd0;
      if (done_o) rises <= '0;
      else if (rd_strobe_o && !strobe_q) rises <= rises + 4'd1;
    end
  end

  // R1: outputs idle right after reset
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!done_o && status_o == 3'd0 && !rd_strobe_o));

  // R2: strobe width
  p_strobe_len_r2: assert property (@(posedge clk) disable iff (rst)
    (strobe_q && !rd_strobe_o) |-> (hi_cnt == 16'(WAIT_CYCLES + 1)));

  // R10: a request performs one or two polls, never a stray read
  p_read_pairs_r10: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (rises == 4'd2 || rises == 4'd4));

  // R9: done is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R9: code moves only with done
  p_status_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(status_o) |-> done_o);

  // R9: code in range when reported
  p_code_legal_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (status_o <= 3'd4));

endmodule

bind flash_toggle_poller ftp_checker #(.WAIT_CYCLES(WAIT_CYCLES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rd_strobe_o (rd_strobe_o),
  .done_o      (done_o),
  .status_o    (status_o)
);

// File: tb/flash_toggle_poller_bench.sv
module flash_toggle_poller_bench;
  localparam int W = 2;
  localparam int P = 2 * W + 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic       rd_strobe_o;
  logic [7:0] rd_data_i = 8'h00;
  logic       done_o;
  logic [2:0] status_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  logic [7:0] vals [4];
  int idx = 0;
  int hc = 0;
  int rc = 0;

  always #10 clk = ~clk;

  flash_toggle_poller #(.DATA_W(8), .WAIT_CYCLES(W)) u_flash_toggle_poller (
    .clk (clk), .rst (rst), .start_i (start_i), .rd_strobe_o (rd_strobe_o),
    .rd_data_i (rd_data_i), .done_o (done_o), .status_o (status_o)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // Device model: drives the true value only in the strobe's last cycle (R2)
  always @(negedge clk) begin
    if (rd_strobe_o) begin
      hc = hc + 1;
      if (hc == 1) rc = rc + 1;
      rd_data_i = (hc == W + 1) ? vals[idx % 4] : ~vals[idx % 4];
    end else if (hc != 0) begin
      chk(hc == W + 1, "R2 strobe width", hc, W + 1);
      hc = 0;
      idx = idx + 1;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  // Behavioural reference of the decision rules
  function automatic void ref_poll(input logic [7:0] v0, v1, v2, v3,
                                   output int code, output int polls);
    logic [7:0] t;
    logic [7:0] d;
    bit fin;
    fin = 0; polls = 1; code = 0;
    for (int p = 0; p < 2; p++) begin
      if (!fin) begin
        t = (p == 0) ? (v0 ^ v1) : (v2 ^ v3);
        d = (p == 0) ? v0 : v2;
        if (t == 8'h00) begin code = 0; fin = 1; end
        else if (t == 8'h04) begin
          if (p == 0) polls = 2; else begin code = 2; fin = 1; end
        end else if (t[6]) begin code = d[5] ? 3 : 1; fin = 1; end
        else begin
          if (p == 0) polls = 2; else begin code = 4; fin = 1; end
        end
      end
    end
  endfunction

  task automatic run(input logic [7:0] v0, v1, v2, v3, input string rq, input bit poke);
    int ecode;
    int npoll;
    int tdone;
    ref_poll(v0, v1, v2, v3, ecode, npoll);
    tdone = P * npoll + 1;
    vals[0] = v0; vals[1] = v1; vals[2] = v2; vals[3] = v3;
    idx = 0; rc = 0;
    @(negedge clk) start_i = 1'b1;
    for (int k = 1; k <= tdone + 2; k++) begin
      @(negedge clk);
      if (k == 1) start_i = 1'b0;
      if (poke && k == 3) start_i = 1'b1;
      if (poke && k == 4) start_i = 1'b0;
      chk(done_o == (k == tdone), {rq, " R9 done timing"}, done_o, k == tdone);
      if (k >= tdone) chk(status_o == 3'(ecode), rq, status_o, ecode);
    end
    chk(rc == 2 * npoll, "R10 read count", rc, 2 * npoll);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!done_o && status_o == 3'd0 && !rd_strobe_o, "R1 reset state", {done_o, status_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!done_o && status_o == 3'd0 && !rd_strobe_o, "R1 after release", {done_o, status_o}, 0);
    run(8'h80, 8'h80, 8'h00, 8'h00, "R3 ready", 1'b0);
    run(8'h40, 8'h00, 8'h00, 8'h00, "R4 busy", 1'b1);
    run(8'h60, 8'h20, 8'h00, 8'h00, "R5 timeout", 1'b0);
    run(8'hFF, 8'hFF, 8'h00, 8'h00, "R5 ff not fault", 1'b0);
    run(8'h04, 8'h00, 8'h00, 8'h04, "R6 erase suspend", 1'b1);
    run(8'h01, 8'h00, 8'h02, 8'h00, "R7 error", 1'b0);
    run(8'h04, 8'h00, 8'h11, 8'h11, "R8 suspend retry ready", 1'b0);
    run(8'h03, 8'h00, 8'h40, 8'h00, "R8 retry busy", 1'b1);
    run(8'h01, 8'h00, 8'h04, 8'h00, "R8 retry suspend", 1'b0);
    run(8'h01, 8'h00, 8'h60, 8'h20, "R8 retry timeout", 1'b0);
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule